// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block chooses the address of the next word fetched from a paged microcode store for a stack-machine core. The store is split into pages that are selected by the upper address bits. Within a page, the lower address bits pick a word. Every cycle the block looks at the control fields of the word currently being executed, along with a zero-test flag and a bytecode stream. From these it registers the address to present next, so the address always reaches the store one cycle after the fields that chose it.

Bytecodes are decoded directly. A fetched bytecode value becomes the in-page word address in page 0, and no table lookup sits in between. Address 0 is the dispatch entry. An instruction can reach it in two ways: by requesting dispatch, or by leaving its follow field at zero. A non-zero follow field names a word in the adjacent page, one page up or one page down. Conditional branches land on one word of an aligned pair, and the zero flag chooses which one.

Some instructions carry an inline operand. These take one operand byte from the bytecode stream through a valid/ready handshake. The block stalls when no byte is on offer. It reports an illegal mix of control bits through a registered error flag.

Top module: `nextAddrSeq`

## Requirements
- R1: A synchronous reset sets the address to 0 and clears the error flag and the operand register.
- R2: When the current address is 0, or the dispatch bit is set, and a bytecode is valid, the next address is that bytecode value in page 0 (bits 9:8 = 0, bits 7:0 = bytecode). `bcReady` is high in that same cycle.
- R3: `bcReady` is high only in a cycle where a byte is taken, and only while `bcValid` is high. A dispatch with no valid bytecode sends the address to 0 and holds it there until a byte arrives.
- R4: Outside a dispatch or a branch, a follow field of zero sends the next address to 0.
- R5: When the follow field is non-zero and the page-back bit is 0, the next address is the follow field in page (current page + 1) modulo 4.
- R6: When the follow field is non-zero and the page-back bit is 1, the next address is the follow field in page (current page − 1) modulo 4.
- R7: A branch keeps the current page and takes bits 7:1 from the follow field. Address bit 0 is 0 when `zeroFlag` is 1 and is 1 when `zeroFlag` is 0.
- R8: An operand instruction with a valid byte raises `bcReady`, loads the byte into the operand register, and advances by the follow rules of R4 to R6.
- R9: An operand instruction with no valid byte keeps the address unchanged and keeps `bcReady` low.
- R10: The illegal mixes are dispatch together with operand, and branch together with either of them. After one of these, the next address is 0, no byte is taken, and the error flag is high for one cycle. A later legal instruction clears the flag.
- R11: At address 0 the control fields are ignored. The block dispatches or waits and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uNextField | input | 8 | Follow field or branch pair base of the current word |
| uPageBack | input | 1 | 0: follow into the next page, 1: follow into the previous page |
| uNxt | input | 1 | Request dispatch of the next bytecode |
| uOpd | input | 1 | Take one operand byte |
| uBranch | input | 1 | Conditional branch to a word pair |
| zeroFlag | input | 1 | Tested value is zero |
| bcValid | input | 1 | Bytecode stream has a byte on offer |
| bcData | input | 8 | Bytecode stream byte |
| bcReady | output | 1 | Byte taken this cycle |
| uAddr | output | 10 | Registered microcode address |
| operand | output | 8 | Last operand byte taken |
| errFlag | output | 1 | Illegal control mix seen in the previous cycle |

## Verification
The bench uses the default geometry: two page bits and eight word bits. With only four pages, a follow upward from page 3 and a follow downward from page 0 are each reachable in a few steps, so both wrap cases are checked directly. The eight-bit word field lets a dispatched bytecode land on any word of page 0. It also lets branch pairs and follow targets reach every page from short setup sequences.

// File: rtl/seqPkg.sv
package seqPkg;
  // Strobes from the control decoder to the address datapath.
  // Exactly one of the five sel* fields is set in every cycle.
  typedef struct packed {
    logic selDispatch;   // load bytecode into page 0
    logic selBranch;     // pair base in current page, condition in bit 0
    logic selFollow;     // follow-field rule (zero -> entry, else adjacent page)
    logic selHold;       // keep address (operand stall)
    logic selZero;       // force the dispatch entry
    logic loadOperand;   // capture the operand byte
    logic flagErr;       // illegal control mix seen
  } seqStrobes_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int PAGE_BITS = 2,
  parameter int WORD_BITS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PAGE_BITS+WORD_BITS-1:0] curAddr,
  input  logic                          uNxt,
  input  logic                          uOpd,
  input  logic                          uBranch,
  input  logic                          bcValid,
  output logic                          bcReady,
  output seqStrobes_t                   strb
);
  localparam int ADDR_W = PAGE_BITS + WORD_BITS;

  logic atEntry;
  logic illegalMix;

  assign atEntry    = (curAddr == '0);
  assign illegalMix = !atEntry && ((uNxt && uOpd) || (uBranch && (uNxt || uOpd)));

  always_comb begin
    strb    = '0;
    bcReady = 1'b0;
    if (illegalMix) begin
      strb.selZero = 1'b1;
      strb.flagErr = 1'b1;
    end else if (atEntry || uNxt) begin
      if (bcValid) begin
        strb.selDispatch = 1'b1;
        bcReady          = 1'b1;
      end else begin
        strb.selZero = 1'b1;
      end
    end else if (uBranch) begin
      strb.selBranch = 1'b1;
    end else if (uOpd) begin
      if (bcValid) begin
        strb.selFollow   = 1'b1;
        strb.loadOperand = 1'b1;
        bcReady          = 1'b1;
      end else begin
        strb.selHold = 1'b1;
      end
    end else begin
      strb.selFollow = 1'b1;
    end
  end

  // R3: a byte is never taken without an offer
  assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    bcReady |-> bcValid);

  // R11: the entry word never reports an illegal mix
  assert_entry_no_err_R11: assert property (@(posedge clk) disable iff (rst)
    (curAddr == ADDR_W'(0)) |-> !strb.flagErr);
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int PAGE_BITS = 2,
  parameter int WORD_BITS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  seqStrobes_t                   strb,
  input  logic [WORD_BITS-1:0]          uNextField,
  input  logic                          uPageBack,
  input  logic                          zeroFlag,
  input  logic [WORD_BITS-1:0]          bcData,
  output logic [PAGE_BITS+WORD_BITS-1:0] addrQ,
  output logic [WORD_BITS-1:0]          operandQ,
  output logic                          errQ
);
  localparam int ADDR_W = PAGE_BITS + WORD_BITS;

  logic [PAGE_BITS-1:0] curPage;
  logic [PAGE_BITS-1:0] adjPage;
  logic [ADDR_W-1:0]    followAddr;
  logic [ADDR_W-1:0]    branchAddr;
  logic [ADDR_W-1:0]    dispatchAddr;
  logic [ADDR_W-1:0]    addrD;

  assign curPage = addrQ[ADDR_W-1 -: PAGE_BITS];
  assign adjPage = uPageBack ? (curPage - PAGE_BITS'(1)) : (curPage + PAGE_BITS'(1));

  assign followAddr   = (uNextField == '0) ? '0 : {adjPage, uNextField};
  assign branchAddr   = {curPage, uNextField[WORD_BITS-1:1], ~zeroFlag};
  assign dispatchAddr = {{PAGE_BITS{1'b0}}, bcData};

  always_comb begin
    addrD = '0;
    unique case (1'b1)
      strb.selDispatch: addrD = dispatchAddr;
      strb.selBranch:   addrD = branchAddr;
      strb.selFollow:   addrD = followAddr;
      strb.selHold:     addrD = addrQ;
      default:          addrD = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      operandQ <= '0;
      errQ     <= 1'b0;
    end else begin
      addrQ <= addrD;
      errQ  <= strb.flagErr;
      if (strb.loadOperand) operandQ <= bcData;
    end
  end

  // R1: reset brings the entry address and a clear flag
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (addrQ == '0 && !errQ && operandQ == '0));

  // control must pick exactly one address source
  assert_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot({strb.selDispatch, strb.selBranch, strb.selFollow, strb.selHold, strb.selZero}));

  // R2: dispatch lands on the bytecode in page 0
  assert_dispatch_target_R2: assert property (@(posedge clk) disable iff (rst)
    strb.selDispatch |=> addrQ == {{PAGE_BITS{1'b0}}, $past(bcData)});

  // R7: branch stays in page, condition supplies bit 0
  assert_branch_pair_R7: assert property (@(posedge clk) disable iff (rst)
    strb.selBranch |=> (addrQ[ADDR_W-1 -: PAGE_BITS] == $past(curPage))
                       && (addrQ[0] == !$past(zeroFlag)));

  // R9: operand stall keeps the address
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    strb.selHold |=> $stable(addrQ));

  // R10: illegal mix returns to entry and raises the flag
  assert_illegal_entry_R10: assert property (@(posedge clk) disable iff (rst)
    strb.flagErr |=> (errQ && addrQ == '0));
endmodule

// File: rtl/nextAddrSeq.sv
module nextAddrSeq
  import seqPkg::*;
#(
  parameter int PAGE_BITS = 2,
  parameter int WORD_BITS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [WORD_BITS-1:0]           uNextField,
  input  logic                           uPageBack,
  input  logic                           uNxt,
  input  logic                           uOpd,
  input  logic                           uBranch,
  input  logic                           zeroFlag,
  input  logic                           bcValid,
  input  logic [WORD_BITS-1:0]           bcData,
  output logic                           bcReady,
  output logic [PAGE_BITS+WORD_BITS-1:0] uAddr,
  output logic [WORD_BITS-1:0]           operand,
  output logic                           errFlag
);
  seqStrobes_t strb;

  seqCtrl #(.PAGE_BITS(PAGE_BITS), .WORD_BITS(WORD_BITS)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .curAddr (uAddr),
    .uNxt    (uNxt),
    .uOpd    (uOpd),
    .uBranch (uBranch),
    .bcValid (bcValid),
    .bcReady (bcReady),
    .strb    (strb)
  );

  seqDatapath #(.PAGE_BITS(PAGE_BITS), .WORD_BITS(WORD_BITS)) uPath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .uNextField (uNextField),
    .uPageBack  (uPageBack),
    .zeroFlag   (zeroFlag),
    .bcData     (bcData),
    .addrQ      (uAddr),
    .operandQ   (operand),
    .errQ       (errFlag)
  );
endmodule

// File: tb/tb_nextAddrSeq.sv
module tb_nextAddrSeq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] uNextField;
  logic       uPageBack, uNxt, uOpd, uBranch, zeroFlag, bcValid;
  logic [7:0] bcData;
  logic       bcReady;
  logic [9:0] uAddr;
  logic [7:0] operand;
  logic       errFlag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextAddrSeq dut (
    .clk(clk), .rst(rst), .uNextField(uNextField), .uPageBack(uPageBack),
    .uNxt(uNxt), .uOpd(uOpd), .uBranch(uBranch), .zeroFlag(zeroFlag),
    .bcValid(bcValid), .bcData(bcData), .bcReady(bcReady),
    .uAddr(uAddr), .operand(operand), .errFlag(errFlag)
  );

  // {startPage, startWord, nxt, opd, br, back, field, zf, valid, byte, expAddr, expReady, expErr}
  localparam logic [43:0] VEC [NVEC] = '{
    {2'd2, 8'h05, 4'b1000, 8'h00, 1'b0, 1'b1, 8'h9C, 10'h09C, 1'b1, 1'b0}, // R2 dispatch bit
    {2'd1, 8'h07, 4'b1000, 8'h00, 1'b0, 1'b0, 8'h00, 10'h000, 1'b0, 1'b0}, // R3 no byte
    {2'd3, 8'h04, 4'b0000, 8'h00, 1'b0, 1'b0, 8'h00, 10'h000, 1'b0, 1'b0}, // R4 zero field
    {2'd1, 8'h03, 4'b0000, 8'h40, 1'b0, 1'b0, 8'h00, 10'h240, 1'b0, 1'b0}, // R5 up
    {2'd3, 8'h03, 4'b0000, 8'h11, 1'b0, 1'b0, 8'h00, 10'h011, 1'b0, 1'b0}, // R5 wrap 3->0
    {2'd2, 8'h09, 4'b0001, 8'h80, 1'b0, 1'b0, 8'h00, 10'h180, 1'b0, 1'b0}, // R6 down
    {2'd0, 8'h09, 4'b0001, 8'h22, 1'b0, 1'b0, 8'h00, 10'h322, 1'b0, 1'b0}, // R6 wrap 0->3
    {2'd2, 8'h06, 4'b0010, 8'h35, 1'b1, 1'b0, 8'h00, 10'h234, 1'b0, 1'b0}, // R7 zero -> even
    {2'd1, 8'h06, 4'b0010, 8'h34, 1'b0, 1'b0, 8'h00, 10'h135, 1'b0, 1'b0}, // R7 nonzero -> odd
    {2'd3, 8'h02, 4'b0100, 8'h10, 1'b0, 1'b0, 8'h00, 10'h302, 1'b0, 1'b0}, // R9 stall
    {2'd0, 8'h05, 4'b0000, 8'h07, 1'b0, 1'b1, 8'h66, 10'h107, 1'b0, 1'b0}, // R3 no take on follow
    {2'd1, 8'h08, 4'b0100, 8'h10, 1'b0, 1'b1, 8'hAB, 10'h210, 1'b1, 1'b0}, // R8 operand taken
    {2'd1, 8'h01, 4'b1100, 8'h20, 1'b0, 1'b1, 8'h55, 10'h000, 1'b0, 1'b1}, // R10 nxt+opd
    {2'd2, 8'h04, 4'b0110, 8'h20, 1'b0, 1'b1, 8'h56, 10'h000, 1'b0, 1'b1}, // R10 br+opd
    {2'd3, 8'h0A, 4'b1010, 8'h20, 1'b1, 1'b1, 8'h57, 10'h000, 1'b0, 1'b1}  // R10 br+nxt
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    uNextField = '0; uPageBack = 0; uNxt = 0; uOpd = 0; uBranch = 0;
    zeroFlag = 0; bcValid = 0; bcData = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // reach page p, word w (w non-zero) by legal instructions only
  task automatic setAddr(input logic [1:0] p, input logic [7:0] w);
    clearIn();
    tick();                       // zero follow field or idle entry -> address 0
    bcValid = 1'b1;
    bcData  = (p == 2'd0) ? w : 8'h01;
    tick();                       // dispatch into page 0
    clearIn();
    for (int i = 0; i < int'(p); i++) begin
      uNextField = (i == int'(p) - 1) ? w : 8'h01;
      tick();
    end
    clearIn();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearIn();
    rst = 1'b1;
    @(negedge clk);
    tick();
    rst = 1'b0;
    chk("R1 reset addr", 32'(uAddr), 32'h0);
    chk("R1 reset err", 32'(errFlag), 32'h0);
    chk("R1 reset operand", 32'(operand), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      setAddr(VEC[v][43:42], VEC[v][41:34]);
      chk("setup addr", 32'(uAddr), 32'({VEC[v][43:42], VEC[v][41:34]}));
      uNxt = VEC[v][33]; uOpd = VEC[v][32]; uBranch = VEC[v][31]; uPageBack = VEC[v][30];
      uNextField = VEC[v][29:22]; zeroFlag = VEC[v][21];
      bcValid = VEC[v][20]; bcData = VEC[v][19:12];
      #1;
      chk($sformatf("R3 vec%0d ready", v), 32'(bcReady), 32'(VEC[v][1]));
      tick();
      chk($sformatf("R2-R10 vec%0d addr", v), 32'(uAddr), 32'(VEC[v][11:2]));
      chk($sformatf("R10 vec%0d err", v), 32'(errFlag), 32'(VEC[v][0]));
      if (v == 11) chk("R8 operand loaded", 32'(operand), 32'hAB);
    end

    // R10: flag clears after a legal word
    clearIn();
    uNextField = 8'h00;
    tick();
    chk("R10 err clears", 32'(errFlag), 32'h0);

    // R9 then R8: stalled operand proceeds once a byte arrives
    setAddr(2'd3, 8'h02);
    uOpd = 1'b1; uNextField = 8'h10;
    tick();
    chk("R9 held addr", 32'(uAddr), 32'h302);
    bcValid = 1'b1; bcData = 8'h3C;
    tick();
    chk("R8 advance after stall", 32'(uAddr), 32'h010);
    chk("R8 operand value", 32'(operand), 32'h3C);

    // R11: fields ignored at address 0
    clearIn();
    tick();
    chk("R11 at entry", 32'(uAddr), 32'h0);
    uNxt = 1'b1; uOpd = 1'b1; uBranch = 1'b1; uNextField = 8'h77;
    tick();
    chk("R11 no error at entry", 32'(errFlag), 32'h0);
    chk("R11 waits at entry", 32'(uAddr), 32'h0);
    bcValid = 1'b1; bcData = 8'h42;
    #1;
    chk("R11 ready at entry", 32'(bcReady), 32'h1);
    tick();
    chk("R11 dispatch ignores fields", 32'(uAddr), 32'h042);

    // R2: bytecode 0 returns to the entry
    clearIn();
    uNxt = 1'b1; bcValid = 1'b1; bcData = 8'h00;
    tick();
    chk("R2 bytecode zero", 32'(uAddr), 32'h0);

    // R1: reset mid-run after an error and an operand load
    setAddr(2'd1, 8'h01);
    uNxt = 1'b1; uOpd = 1'b1;
    tick();
    chk("R10 pre-reset err", 32'(errFlag), 32'h1);
    clearIn();
    setAddr(2'd2, 8'h05);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 mid reset addr", 32'(uAddr), 32'h0);
    chk("R1 mid reset operand", 32'(operand), 32'h0);
    chk("R1 mid reset err", 32'(errFlag), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule